// File: doc/BRIEF.md
# Implicit Message Routing Decoder

This block looks at the 5-bit Type field of an inbound transaction-layer packet and decides where the packet goes. It uses only the message routing code and the side of the port the packet came in on. For a packet that is not a message, it returns a pass-through verdict, and other routing logic makes the decision. A message that names address routing or ID routing is handed to those checkers. For every other message the block applies the implicit rules itself. The result is accept here, send toward the root, copy to every downstream port, reject, or flag as malformed.

A single parameter sets the role. An endpoint has only one link, so it ignores the ingress side. A switch port needs to know whether the packet arrived on its upstream port or on one of its downstream ports. The same code can be legal on one side and illegal on the other. The decision logic is purely combinational and feeds a single output register, so the result appears exactly one clock after the request.

The register has only two states. When idle, it shows a pass-through verdict with an empty mask. When holding, it shows the verdict latched from the request presented in the previous cycle. The transition from idle to holding, and from holding to holding, happens on a cycle with `in_valid` high. The transition back to idle happens on a cycle with `in_valid` low.

Top module: `msg_route_dec`

## Requirements
- R1: The outputs `out_valid`, `out_verdict` and `out_bcast_mask` reflect the request presented on the previous clock edge. `out_valid` equals `in_valid` delayed by one cycle. The verdict encoding is: 0 pass, 1 local accept, 2 upstream, 3 broadcast, 4 address check, 5 ID check, 6 reject, 7 malformed.
- R2: When Type bits [4:3] are not binary 10, the packet is not a message, and the verdict is pass (0) with an empty mask.
- R3: A message whose header-size flag `in_hdr4dw` is 0 (three-dword header) gets verdict malformed (7), whatever its routing code.
- R4: A four-dword message whose routing code (Type bits [2:0]) is 110 or 111 gets verdict malformed (7).
- R5: Routing code 001 gives the address-check verdict (4), and code 010 gives the ID-check verdict (5), in both roles and from both sides.
- R6: Routing code 100 (terminate at receiver) gives local accept (1) in both roles and from both sides.
- R7: In switch role, codes 000 and 101 (toward the root) give upstream (2) when they arrive from a downstream port, and reject (6) when they arrive on the upstream port.
- R8: In switch role, code 011 (broadcast from the root) gives broadcast (3) with every bit of the downstream port mask set when it arrives on the upstream port, and malformed (7) when it arrives from a downstream port.
- R9: In endpoint role, code 011 gives local accept (1), and codes 000 and 101 give reject (6). The ingress-side input has no effect on any verdict.
- R10: The mask is all zeros for every verdict other than broadcast. While reset is held, and in the cycle after `in_valid` is low, `out_valid` is 0, the verdict is pass (0) and the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request is present this cycle |
| in_type | input | 5 | Type field of the packet header |
| in_hdr4dw | input | 1 | 1 = four-dword header, 0 = three-dword header |
| in_from_dn | input | 1 | 1 = arrived on a downstream port, 0 = arrived on the upstream port |
| out_valid | output | 1 | Verdict is valid |
| out_verdict | output | 3 | Routing verdict (encoding in R1) |
| out_bcast_mask | output | NUM_DN | Downstream ports to copy a broadcast to |

## Verification
The hardest case to reach is a message that is legal on one ingress side and illegal on the other. For example, a root-bound code must be forwarded when it comes from below and rejected when it comes from above. To reach every such case, the stimulus sweeps all 32 Type values against both header sizes and both ingress sides. It drives the same stimulus into a switch-role instance and an endpoint-role instance at once, so the two role variants are compared on identical input. Idle cycles between requests show the register returning to its empty state.

// File: rtl/msg_route_pkg.sv
package msg_route_pkg;

    typedef enum logic [2:0] {
        VD_PASS      = 3'd0,
        VD_LOCAL     = 3'd1,
        VD_UP        = 3'd2,
        VD_BCAST     = 3'd3,
        VD_ADDR      = 3'd4,
        VD_ID        = 3'd5,
        VD_REJECT    = 3'd6,
        VD_MALFORMED = 3'd7
    } verdict_e;

    localparam logic [1:0] MSG_CLASS = 2'b10;

    localparam logic [2:0] RC_TO_ROOT   = 3'b000;
    localparam logic [2:0] RC_ADDR      = 3'b001;
    localparam logic [2:0] RC_ID        = 3'b010;
    localparam logic [2:0] RC_BCAST     = 3'b011;
    localparam logic [2:0] RC_LOCAL     = 3'b100;
    localparam logic [2:0] RC_GATHER    = 3'b101;

endpackage

// File: rtl/msg_type_split.sv
module msg_type_split (
    input  logic [4:0] type_i,
    output logic       is_msg_o,
    output logic [2:0] code_o
);
    import msg_route_pkg::*;

    always_comb begin
        is_msg_o = (type_i[4:3] == MSG_CLASS);
        code_o   = type_i[2:0];
    end
endmodule

// File: rtl/msg_route_rules.sv
module msg_route_rules #(
    parameter bit IS_SWITCH = 1'b1
) (
    input  logic                      is_msg_i,
    input  logic [2:0]                code_i,
    input  logic                      hdr4dw_i,
    input  logic                      from_dn_i,
    output msg_route_pkg::verdict_e   verdict_o
);
    import msg_route_pkg::*;

    verdict_e root_vd;
    verdict_e bcast_vd;

    generate
        if (IS_SWITCH) begin : g_switch
            always_comb begin
                root_vd  = from_dn_i ? VD_UP : VD_REJECT;
                bcast_vd = from_dn_i ? VD_MALFORMED : VD_BCAST;
            end
        end else begin : g_endpoint
            always_comb begin
                root_vd  = VD_REJECT;
                bcast_vd = VD_LOCAL;
            end
        end
    endgenerate

    always_comb begin
        verdict_o = VD_PASS;
        if (!is_msg_i) begin
            verdict_o = VD_PASS;
        end else if (!hdr4dw_i) begin
            verdict_o = VD_MALFORMED;
        end else begin
            unique case (code_i)
                RC_TO_ROOT, RC_GATHER: verdict_o = root_vd;
                RC_ADDR:               verdict_o = VD_ADDR;
                RC_ID:                 verdict_o = VD_ID;
                RC_BCAST:              verdict_o = bcast_vd;
                RC_LOCAL:              verdict_o = VD_LOCAL;
                default:               verdict_o = VD_MALFORMED;
            endcase
        end
    end
endmodule

// File: rtl/msg_route_dec.sv
module msg_route_dec #(
    parameter bit          IS_SWITCH = 1'b1,
    parameter int unsigned NUM_DN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_type,
    input  logic              in_hdr4dw,
    input  logic              in_from_dn,
    output logic              out_valid,
    output logic [2:0]        out_verdict,
    output logic [NUM_DN-1:0] out_bcast_mask
);
    import msg_route_pkg::*;

    localparam logic [NUM_DN-1:0] ALL_DN = {NUM_DN{1'b1}};

    typedef enum logic {ST_IDLE, ST_HOLD} hold_state_e;

    hold_state_e       state_q, state_d;
    verdict_e          vd_comb, vd_q, vd_d;
    logic [NUM_DN-1:0] mask_q, mask_d;
    logic              is_msg;
    logic [2:0]        code;
    logic              run_q;

    msg_type_split u_split (
        .type_i   (in_type),
        .is_msg_o (is_msg),
        .code_o   (code)
    );

    msg_route_rules #(.IS_SWITCH(IS_SWITCH)) u_rules (
        .is_msg_i  (is_msg),
        .code_i    (code),
        .hdr4dw_i  (in_hdr4dw),
        .from_dn_i (in_from_dn),
        .verdict_o (vd_comb)
    );

    always_comb begin
        state_d = in_valid ? ST_HOLD : ST_IDLE;
        vd_d    = VD_PASS;
        mask_d  = '0;
        unique case (state_d)
            ST_HOLD: begin
                vd_d   = vd_comb;
                mask_d = (vd_comb == VD_BCAST) ? ALL_DN : '0;
            end
            ST_IDLE: begin
                vd_d   = VD_PASS;
                mask_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vd_q    <= VD_PASS;
            mask_q  <= '0;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vd_q    <= vd_d;
            mask_q  <= mask_d;
            run_q   <= 1'b1;
        end
    end

    always_comb begin
        out_valid      = (state_q == ST_HOLD);
        out_verdict    = vd_q;
        out_bcast_mask = mask_q;
    end

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (out_valid == $past(in_valid)));

    // R2
    non_msg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type[4:3] != 2'b10) |=> (out_verdict == 3'd0));

    // R3
    short_hdr_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type[4:3] == 2'b10 && !in_hdr4dw) |=> (out_verdict == 3'd7));

    // R10
    mask_only_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_verdict != 3'd3) |-> (out_bcast_mask == '0));

    // R10
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_verdict == 3'd0 && out_bcast_mask == '0));

    // R6
    local_any_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 5'b10100 && in_hdr4dw) |=> (out_verdict == 3'd1));
endmodule

// File: tb/msg_route_dec_tb.sv
module msg_route_dec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NDN = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic [4:0] in_type;
    logic in_hdr4dw;
    logic in_from_dn;
    logic sw_valid, ep_valid;
    logic [2:0] sw_vd, ep_vd;
    logic [NDN-1:0] sw_mask, ep_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_route_dec #(.IS_SWITCH(1'b1), .NUM_DN(NDN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_hdr4dw(in_hdr4dw), .in_from_dn(in_from_dn),
        .out_valid(sw_valid), .out_verdict(sw_vd), .out_bcast_mask(sw_mask));

    msg_route_dec #(.IS_SWITCH(1'b0), .NUM_DN(NDN)) dut_ep_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_hdr4dw(in_hdr4dw), .in_from_dn(in_from_dn),
        .out_valid(ep_valid), .out_verdict(ep_vd), .out_bcast_mask(ep_mask));

    function automatic logic [2:0] exp_vd(bit sw, logic [4:0] t, bit h4, bit dn);
        if (t[4:3] != 2'b10) return 3'd0;
        if (!h4) return 3'd7;
        case (t[2:0])
            3'b000, 3'b101: return sw ? (dn ? 3'd2 : 3'd6) : 3'd6;
            3'b001: return 3'd4;
            3'b010: return 3'd5;
            3'b011: return sw ? (dn ? 3'd7 : 3'd3) : 3'd1;
            3'b100: return 3'd1;
            default: return 3'd7;
        endcase
    endfunction

    function automatic string tag_of(bit sw, logic [4:0] t, bit h4);
        if (t[4:3] != 2'b10) return "R2";
        if (!h4) return "R3";
        case (t[2:0])
            3'b110, 3'b111: return "R4";
            3'b001, 3'b010: return "R5";
            3'b100: return "R6";
            default: return sw ? (t[2:0] == 3'b011 ? "R8" : "R7") : "R9";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_type = 5'b10011; in_hdr4dw = 1'b1; in_from_dn = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset sw valid", 32'(sw_valid), 0);
        chk("R10", "reset sw verdict", 32'(sw_vd), 0);
        chk("R10", "reset sw mask", 32'(sw_mask), 0);
        chk("R10", "reset ep valid", 32'(ep_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 32; t++) begin
            for (int h = 0; h < 2; h++) begin
                for (int d = 0; d < 2; d++) begin
                    in_valid = 1'b1; in_type = 5'(t); in_hdr4dw = h[0]; in_from_dn = d[0];
                    @(negedge clk);
                    // R1 one-cycle latency
                    chk("R1", "sw valid", 32'(sw_valid), 1);
                    chk("R1", "ep valid", 32'(ep_valid), 1);
                    chk(tag_of(1, 5'(t), h[0]), "sw verdict", 32'(sw_vd),
                        32'(exp_vd(1, 5'(t), h[0], d[0])));
                    chk(tag_of(0, 5'(t), h[0]), "ep verdict", 32'(ep_vd),
                        32'(exp_vd(0, 5'(t), h[0], d[0])));
                    chk(exp_vd(1, 5'(t), h[0], d[0]) == 3'd3 ? "R8" : "R10", "sw mask",
                        32'(sw_mask), exp_vd(1, 5'(t), h[0], d[0]) == 3'd3 ? 32'hF : 32'h0);
                    chk("R10", "ep mask", 32'(ep_mask), 0);
                    if (t % 3 == 0) begin
                        in_valid = 1'b0; in_type = 5'b10011; in_from_dn = 1'b0;
                        @(negedge clk);
                        // R10 idle after valid low
                        chk("R10", "idle sw valid", 32'(sw_valid), 0);
                        chk("R10", "idle sw verdict", 32'(sw_vd), 0);
                        chk("R10", "idle sw mask", 32'(sw_mask), 0);
                    end
                end
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule